// File: doc/BRIEF.md
# UART Modem-Control Loopback Unit

This unit is the internal loopback path of a serial port. A control register write carries a loopback-enable bit and four software-driven modem outputs (request-to-send, data-terminal-ready and two general outputs). While loopback is on, those outputs are fed straight back into the four modem-status flags on the same control write. The modem-status interrupt bits are cleared and then rebuilt from the looped-back levels, and a one-cycle update pulse tells the interrupt logic to take the new values.

In loopback, each host write to the data register lands in the receive buffer through a push port. A rising send-break bit in line control pushes a break entry. Anything that arrives from the external receiver is dropped. With loopback off, the unit passes external characters and breaks to the receive buffer, and the modem flags follow the external modem pins through one register stage.

The host bus issues at most one of the control, data and line-control write strobes per cycle. Every result appears on the clock edge that follows the stimulus.

Top module: `uart_modem_loop`

## Requirements
- R1: After reset, `modem_flags` is 0, `push_valid` and `ms_upd` are 0, and loopback is off.
- R2: A control write with `ctrl_loop`=1 loads the flags one cycle later, including the write that first sets loopback. The flag bits are RI at bit 3, DCD at bit 2, DSR at bit 1 and CTS at bit 0. The control bits are OUT2 at bit 3, OUT1 at bit 2, DTR at bit 1 and RTS at bit 0. RI takes OUT2, DCD takes OUT1, DSR takes DTR and CTS takes RTS.
- R3: On that same write, `ms_upd` is 1 for exactly one cycle. In that cycle `ms_val` holds all four modem interrupt bits, in the flag bit order, with each bit cleared and then set only if its looped-back flag is 1.
- R4: `ms_upd` stays 0 in every cycle that does not follow a control write with `ctrl_loop`=1.
- R5: In loopback, a data write produces `push_valid`=1 one cycle later, with `push_brk`=0 and `push_data` equal to the written character.
- R6: In loopback, `ext_rx_valid` and `ext_brk` cause no push.
- R7: In loopback, a line-control write that changes the break bit from 0 to 1 pushes one entry with `push_brk`=1 and `push_data`=0. A write that keeps the bit at 1, or clears it, pushes nothing.
- R8: With loopback off, `modem_flags` equals `pin_modem` as sampled one cycle earlier, and a control write with `ctrl_loop`=0 does not load `ctrl_mdm` into the flags.
- R9: With loopback off, `ext_rx_valid` pushes its character and `ext_brk` pushes a break entry. If both arrive in the same cycle, the break wins. Data writes and line-control break writes push nothing.
- R10: While loopback is on and no control write occurs, the flags hold their value whatever `pin_modem` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_loop | input | 1 | Loopback-enable bit of the control write |
| ctrl_mdm | input | 4 | Modem outputs {OUT2, OUT1, DTR, RTS} of the control write |
| dr_wr | input | 1 | Data register write strobe |
| dr_wdata | input | DATA_W | Character written to the data register |
| lcr_wr | input | 1 | Line-control write strobe |
| lcr_brk | input | 1 | Send-break bit of the line-control write |
| ext_rx_valid | input | 1 | Character from the external receiver |
| ext_rx_data | input | DATA_W | External received character |
| ext_brk | input | 1 | Break event from the external receiver |
| pin_modem | input | 4 | External modem status pins {RI, DCD, DSR, CTS} |
| modem_flags | output | 4 | Modem flags {RI, DCD, DSR, CTS} |
| ms_upd | output | 1 | Modem interrupt bits update pulse |
| ms_val | output | 4 | Rebuilt modem interrupt bits, flag order |
| push_valid | output | 1 | Push into the receive buffer |
| push_brk | output | 1 | Pushed entry is a break |
| push_data | output | DATA_W | Pushed character |

## Verification
Every result of this unit is due exactly one clock edge after the strobe or pin change that causes it:
- the flags and the modem interrupt update after a control write;
- a push after a data write, a break edge or an external character;
- the flags after a pin change when loopback is off.

Each task in the bench drives its strobes just after a falling edge and holds them for one cycle. It then samples at the next falling edge, which lies between that rising edge and the following one. To catch pulses that last too long, the task also looks one cycle later for `push_valid` and `ms_upd` having returned to 0.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;

    localparam int MDM_N = 4;

    // Flag order: bit3 RI, bit2 DCD, bit1 DSR, bit0 CTS
    typedef struct packed {
        logic ri;
        logic dcd;
        logic dsr;
        logic cts;
    } mdm_flags_t;

    // Control order: bit3 OUT2, bit2 OUT1, bit1 DTR, bit0 RTS
    typedef struct packed {
        logic out2;
        logic out1;
        logic dtr;
        logic rts;
    } mdm_ctrl_t;

    typedef enum logic [1:0] {
        PK_NONE  = 2'd0,
        PK_DATA  = 2'd1,
        PK_BREAK = 2'd2
    } push_kind_e;

    function automatic mdm_flags_t loop_map(input mdm_ctrl_t c);
        mdm_flags_t f;
        f.ri  = c.out2;
        f.dcd = c.out1;
        f.dsr = c.dtr;
        f.cts = c.rts;
        return f;
    endfunction

    function automatic push_kind_e pick_source(
        input logic loop_on,
        input logic loop_brk,
        input logic loop_data,
        input logic ext_brk,
        input logic ext_data
    );
        if (loop_on) begin
            if (loop_brk)       return PK_BREAK;
            else if (loop_data) return PK_DATA;
        end else begin
            if (ext_brk)        return PK_BREAK;
            else if (ext_data)  return PK_DATA;
        end
        return PK_NONE;
    endfunction

endpackage

// File: rtl/lb_mode_reg.sv
module lb_mode_reg (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic ctrl_loop,
    output logic loop_q
);
    always_ff @(posedge clk) begin
        if (rst)          loop_q <= 1'b0;
        else if (ctrl_wr) loop_q <= ctrl_loop;
    end
endmodule

// File: rtl/lb_modem_flags.sv
module lb_modem_flags
    import uart_lb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  logic             ctrl_loop,
    input  logic             loop_q,
    input  logic [MDM_N-1:0] ctrl_mdm,
    input  logic [MDM_N-1:0] pin_modem,
    output logic [MDM_N-1:0] flags_q,
    output logic             ms_upd_q,
    output logic [MDM_N-1:0] ms_val_q
);
    logic             load_loop;
    mdm_flags_t       looped;
    logic [MDM_N-1:0] looped_v;
    logic [MDM_N-1:0] flags_d;

    assign load_loop = ctrl_wr && ctrl_loop;
    assign looped    = loop_map(mdm_ctrl_t'(ctrl_mdm));
    assign looped_v  = looped;

    for (genvar i = 0; i < MDM_N; i++) begin : g_bit
        always_comb begin
            if (load_loop)   flags_d[i] = looped_v[i];
            else if (loop_q) flags_d[i] = flags_q[i];
            else             flags_d[i] = pin_modem[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q  <= '0;
            ms_upd_q <= 1'b0;
            ms_val_q <= '0;
        end else begin
            flags_q  <= flags_d;
            ms_upd_q <= load_loop;
            if (load_loop) begin
                // clear all modem interrupt bits, then set from looped levels
                ms_val_q <= '0;
                for (int i = 0; i < MDM_N; i++)
                    if (looped_v[i]) ms_val_q[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lb_break_edge.sv
module lb_break_edge (
    input  logic clk,
    input  logic rst,
    input  logic lcr_wr,
    input  logic lcr_brk,
    input  logic loop_q,
    output logic brk_req
);
    logic brk_q;

    always_ff @(posedge clk) begin
        if (rst)         brk_q <= 1'b0;
        else if (lcr_wr) brk_q <= lcr_brk;
    end

    assign brk_req = loop_q && lcr_wr && lcr_brk && !brk_q;
endmodule

// File: rtl/lb_push_sel.sv
module lb_push_sel
    import uart_lb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loop_q,
    input  logic              loop_brk,
    input  logic              dr_wr,
    input  logic [DATA_W-1:0] dr_wdata,
    input  logic              ext_rx_valid,
    input  logic [DATA_W-1:0] ext_rx_data,
    input  logic              ext_brk,
    output logic              push_valid,
    output logic              push_brk,
    output logic [DATA_W-1:0] push_data
);
    push_kind_e        kind;
    logic [DATA_W-1:0] char_sel;

    assign kind     = pick_source(loop_q, loop_brk, dr_wr, ext_brk, ext_rx_valid);
    assign char_sel = loop_q ? dr_wdata : ext_rx_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            push_valid <= 1'b0;
            push_brk   <= 1'b0;
            push_data  <= '0;
        end else begin
            push_valid <= (kind != PK_NONE);
            push_brk   <= (kind == PK_BREAK);
            push_data  <= (kind == PK_DATA) ? char_sel : '0;
        end
    end
endmodule

// File: rtl/uart_modem_loop.sv
module uart_modem_loop
    import uart_lb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              ctrl_loop,
    input  logic [3:0]        ctrl_mdm,
    input  logic              dr_wr,
    input  logic [DATA_W-1:0] dr_wdata,
    input  logic              lcr_wr,
    input  logic              lcr_brk,
    input  logic              ext_rx_valid,
    input  logic [DATA_W-1:0] ext_rx_data,
    input  logic              ext_brk,
    input  logic [3:0]        pin_modem,
    output logic [3:0]        modem_flags,
    output logic              ms_upd,
    output logic [3:0]        ms_val,
    output logic              push_valid,
    output logic              push_brk,
    output logic [DATA_W-1:0] push_data
);
    logic loop_q;
    logic brk_req;

    lb_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .ctrl_loop(ctrl_loop),
        .loop_q   (loop_q)
    );

    lb_modem_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .ctrl_loop(ctrl_loop),
        .loop_q   (loop_q),
        .ctrl_mdm (ctrl_mdm),
        .pin_modem(pin_modem),
        .flags_q  (modem_flags),
        .ms_upd_q (ms_upd),
        .ms_val_q (ms_val)
    );

    lb_break_edge u_brk (
        .clk    (clk),
        .rst    (rst),
        .lcr_wr (lcr_wr),
        .lcr_brk(lcr_brk),
        .loop_q (loop_q),
        .brk_req(brk_req)
    );

    lb_push_sel #(.DATA_W(DATA_W)) u_push (
        .clk         (clk),
        .rst         (rst),
        .loop_q      (loop_q),
        .loop_brk    (brk_req),
        .dr_wr       (dr_wr),
        .dr_wdata    (dr_wdata),
        .ext_rx_valid(ext_rx_valid),
        .ext_rx_data (ext_rx_data),
        .ext_brk     (ext_brk),
        .push_valid  (push_valid),
        .push_brk    (push_brk),
        .push_data   (push_data)
    );
endmodule

// File: rtl/uart_modem_loop_chk.sv
module uart_modem_loop_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ctrl_wr,
    input logic              ctrl_loop,
    input logic [3:0]        ctrl_mdm,
    input logic              dr_wr,
    input logic [DATA_W-1:0] dr_wdata,
    input logic              lcr_wr,
    input logic              ext_brk,
    input logic [3:0]        pin_modem,
    input logic [3:0]        modem_flags,
    input logic              ms_upd,
    input logic [3:0]        ms_val,
    input logic              push_valid,
    input logic              push_brk,
    input logic [DATA_W-1:0] push_data,
    input logic              loop_q
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_LOOP_MAP: assert property (@(posedge clk) disable iff (rst)
        past_ok && ctrl_wr && ctrl_loop |=> modem_flags == {$past(ctrl_mdm[3]), $past(ctrl_mdm[2]), $past(ctrl_mdm[1]), $past(ctrl_mdm[0])}); // R2

    AST_MS_REBUILD: assert property (@(posedge clk) disable iff (rst)
        past_ok && ctrl_wr && ctrl_loop |=> ms_upd && ms_val == modem_flags); // R3

    AST_MS_QUIET: assert property (@(posedge clk) disable iff (rst)
        past_ok && !(ctrl_wr && ctrl_loop) |=> !ms_upd); // R4

    AST_DR_PUSH: assert property (@(posedge clk) disable iff (rst)
        past_ok && loop_q && dr_wr |=> push_valid && !push_brk && push_data == $past(dr_wdata)); // R5

    AST_EXT_DROP: assert property (@(posedge clk) disable iff (rst)
        past_ok && loop_q && !dr_wr && !lcr_wr |=> !push_valid); // R6

    AST_PIN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        past_ok && !loop_q && !(ctrl_wr && ctrl_loop) |=> modem_flags == $past(pin_modem)); // R8

    AST_EXT_BREAK: assert property (@(posedge clk) disable iff (rst)
        past_ok && !loop_q && ext_brk |=> push_valid && push_brk); // R9

    AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        past_ok && loop_q && !ctrl_wr |=> $stable(modem_flags)); // R10
endmodule

bind uart_modem_loop uart_modem_loop_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (ctrl_wr),
    .ctrl_loop  (ctrl_loop),
    .ctrl_mdm   (ctrl_mdm),
    .dr_wr      (dr_wr),
    .dr_wdata   (dr_wdata),
    .lcr_wr     (lcr_wr),
    .ext_brk    (ext_brk),
    .pin_modem  (pin_modem),
    .modem_flags(modem_flags),
    .ms_upd     (ms_upd),
    .ms_val     (ms_val),
    .push_valid (push_valid),
    .push_brk   (push_brk),
    .push_data  (push_data),
    .loop_q     (loop_q)
);

// File: tb/uart_modem_loop_bench.sv
module uart_modem_loop_bench;
    localparam int DATA_W   = 8;
    localparam int CLK_PER  = 10;
    localparam int WD_LIMIT = 5000;

    logic              clk = 1'b0;
    logic              rst;
    logic              ctrl_wr, ctrl_loop;
    logic [3:0]        ctrl_mdm;
    logic              dr_wr;
    logic [DATA_W-1:0] dr_wdata;
    logic              lcr_wr, lcr_brk;
    logic              ext_rx_valid;
    logic [DATA_W-1:0] ext_rx_data;
    logic              ext_brk;
    logic [3:0]        pin_modem;
    logic [3:0]        modem_flags;
    logic              ms_upd;
    logic [3:0]        ms_val;
    logic              push_valid, push_brk;
    logic [DATA_W-1:0] push_data;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    uart_modem_loop #(.DATA_W(DATA_W)) u_uart_modem_loop (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        ctrl_wr = 0; ctrl_loop = 0; ctrl_mdm = 0;
        dr_wr = 0; dr_wdata = 0; lcr_wr = 0; lcr_brk = 0;
        ext_rx_valid = 0; ext_rx_data = 0; ext_brk = 0;
    endtask

    // end strobe cycle: wait past the edge, drop strobes
    task automatic step();
        @(negedge clk);
        ctrl_wr = 0; dr_wr = 0; lcr_wr = 0; ext_rx_valid = 0; ext_brk = 0;
    endtask

    task automatic ctrl_write(input logic lp, input logic [3:0] m);
        ctrl_wr = 1; ctrl_loop = lp; ctrl_mdm = m;
        step();
    endtask

    task automatic t_reset();
        rst = 1; idle(); pin_modem = 4'b0110;
        repeat (3) @(negedge clk);
        chk("R1 flags", modem_flags, 0);
        chk("R1 push_valid", push_valid, 0);
        chk("R1 ms_upd", ms_upd, 0);
        rst = 0; pin_modem = 0;
        @(negedge clk);
    endtask

    task automatic t_pins();
        pin_modem = 4'b1001;
        @(negedge clk);
        chk("R8 pins follow", modem_flags, 4'b1001);
        pin_modem = 4'b0101;
        ctrl_write(1'b0, 4'b1010);
        chk("R8 ctrl write no loop", modem_flags, 4'b0101);
        chk("R4 no upd without loop", ms_upd, 0);
    endtask

    task automatic t_loop_map();
        ctrl_write(1'b1, 4'b1010);
        chk("R2 map on enabling write", modem_flags, 4'b1010);
        chk("R3 upd pulse", ms_upd, 1);
        chk("R3 rebuilt bits", ms_val, 4'b1010);
        @(negedge clk);
        chk("R3 pulse one cycle", ms_upd, 0);
        ctrl_write(1'b1, 4'b0101);
        chk("R2 map remap", modem_flags, 4'b0101);
        chk("R3 cleared then set", ms_val, 4'b0101);
        pin_modem = 4'b1111;
        repeat (2) @(negedge clk);
        chk("R10 hold vs pins", modem_flags, 4'b0101);
        chk("R4 quiet", ms_upd, 0);
    endtask

    task automatic t_loop_data();
        dr_wr = 1; dr_wdata = 8'hA5;
        step();
        chk("R5 push valid", push_valid, 1);
        chk("R5 push brk", push_brk, 0);
        chk("R5 push data", push_data, 8'hA5);
        ext_rx_valid = 1; ext_rx_data = 8'h3C;
        step();
        chk("R6 ext data dropped", push_valid, 0);
        ext_brk = 1;
        step();
        chk("R6 ext break dropped", push_valid, 0);
    endtask

    task automatic t_loop_break();
        lcr_wr = 1; lcr_brk = 1;
        step();
        chk("R7 break push", push_valid, 1);
        chk("R7 break flag", push_brk, 1);
        chk("R7 break data", push_data, 0);
        lcr_wr = 1; lcr_brk = 1;
        step();
        chk("R7 held break no push", push_valid, 0);
        lcr_wr = 1; lcr_brk = 0;
        step();
        chk("R7 clear no push", push_valid, 0);
    endtask

    task automatic t_normal_rx();
        ctrl_write(1'b0, 4'b0000);
        @(negedge clk);
        chk("R8 pins after loop off", modem_flags, 4'b1111);
        ext_rx_valid = 1; ext_rx_data = 8'h5E;
        step();
        chk("R9 ext data push", push_valid, 1);
        chk("R9 ext data value", push_data, 8'h5E);
        ext_rx_valid = 1; ext_rx_data = 8'h11; ext_brk = 1;
        step();
        chk("R9 break wins", push_brk, 1);
        chk("R9 break data zero", push_data, 0);
        dr_wr = 1; dr_wdata = 8'h77;
        step();
        chk("R9 dr no push", push_valid, 0);
        lcr_wr = 1; lcr_brk = 1;
        step();
        chk("R9 lcr break no push", push_valid, 0);
    endtask

    initial begin
        for (int n = 0; n < WD_LIMIT; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_pins();
        t_loop_map();
        t_loop_data();
        t_loop_break();
        t_normal_rx();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule